// File: doc/BRIEF.md
# Glitch-Free Clock Group Stop Gate

This block sits between a running source clock and a group of clock outputs. It parks the whole group low, and later brings it back, in response to an active-low stop request that may arrive at any time with no relation to the clock. The request passes through a synchronizer chain of parameterized depth. A small controller then decides when the group may actually stop. Each output has its own gate cell. The cell latches its enable on the falling edge of the source clock and ANDs it with the clock, so an output never shows a shortened high or low phase.

Two parameters set the timing: the synchronizer depth fixes the stop and restart latency, and the minimum run length enforces how many pulses the group delivers before it may stop again. This lets one design serve a fast processor clock group with a long minimum run and a short-latency bus clock group. A per-output enable mask, normally driven from configuration registers, holds selected outputs low regardless of the group state. A status flag tells the outside world whether the group is currently stopped.

Top module: `clk_stop_gate`

## Requirements
- R1: When `stop_req_n` is first sampled low at rising edge k, and the minimum run is already satisfied, the outputs still pulse at edges k through k+SYNC_STAGES and pulse no more from edge k+SYNC_STAGES+1. `stopped_o` reads 1 from edge k+SYNC_STAGES.
- R2: When `stop_req_n` is first sampled high at rising edge k while stopped, `stopped_o` reads 0 from edge k+SYNC_STAGES and enabled outputs pulse again from edge k+SYNC_STAGES+1.
- R3: While the group is stopped, every output is held at logic 0.
- R4: Every output pulse is a full high phase of the source clock. Outputs are low throughout every low phase, and an output's enable changes only on a falling edge of the source clock.
- R5: An output whose mask bit is 0 is held low and does not switch. An output whose mask bit is 1 follows the group state. A mask change takes effect from the next falling edge. While the group is stopped, mask changes have no visible effect.
- R6: After reset release or after a restart, the group delivers at least MIN_RUN pulses before it stops. A stop request that is synchronized earlier is deferred, and the group stops at the edge where the MIN_RUN-th pulse is produced.
- R7: A deferred stop request that is withdrawn before the minimum run completes causes no stop.
- R8: While `rst_n` is low, all outputs are low and `stopped_o` is 0. Enabled outputs pulse from the first rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock of the group |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop request |
| out_en_mask | input | N_OUT | Per-output enable, 1 lets the output run |
| gclk_o | output | N_OUT | Gated clock outputs |
| stopped_o | output | 1 | 1 while the group is stopped |

## Verification
The embedded assertions check on every cycle that the group stops only after a synchronized request and after the minimum run count. They also check that it restarts only once the synchronized request is released, and that a gate whose enable or mask was low at a falling edge shows no high phase at the next one. The exact latency counts, the number of pulses delivered in a deferred run, and the full width of each high phase can only be shown by the bench scenarios. The same holds for a mask change while stopped staying invisible and for a withdrawn request never stopping the group. The bench samples each output twice in the high phase and once in the low phase against a queue of per-cycle expectations.

// File: rtl/clk_stop_pkg.sv
// Shared types for the clock stop gate.
// Assumes: nothing beyond IEEE 1800-2017.
package clk_stop_pkg;

    // Run state of a clock group
    typedef enum logic {
        GRP_HALT = 1'b0,
        GRP_RUN  = 1'b1
    } grp_state_e;

endpackage

// File: rtl/stop_sync.sv
// Synchronizer chain for the asynchronous active-low stop request.
// Assumes: STAGES >= 1; the output idles at "no request" while in reset.
module stop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic req_n_i,
    output logic stop_o
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Single-stage capture of the raw request
            always_ff @(posedge clk_i) begin
                if (!rst_n) chain_q <= 1'b1;
                else        chain_q <= req_n_i;
            end
        end else begin : g_multi
            // Shift the raw request through the chain
            always_ff @(posedge clk_i) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], req_n_i};
            end
        end
    endgenerate

    assign stop_o = ~chain_q[STAGES-1];

endmodule

// File: rtl/run_ctrl.sv
// Group run controller: decides when the group stops and restarts,
// deferring a stop until MIN_RUN pulses have been delivered.
// Assumes: stop_i is already synchronized to clk_i; MIN_RUN >= 1.
module run_ctrl
    import clk_stop_pkg::*;
#(
    parameter int MIN_RUN = 100
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic stop_i,
    output logic run_o
);

    localparam int CNT_W = (MIN_RUN > 1) ? $clog2(MIN_RUN) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MIN_RUN - 1);

    grp_state_e       state_q;
    logic [CNT_W-1:0] run_cnt_q;

    // State and minimum-run counter update
    always_ff @(posedge clk_i) begin
        if (!rst_n) begin
            state_q   <= GRP_RUN;
            run_cnt_q <= '0;
        end else if (state_q == GRP_RUN) begin
            if (stop_i && run_cnt_q >= CNT_LAST) begin
                state_q <= GRP_HALT;
            end else if (run_cnt_q < CNT_LAST) begin
                run_cnt_q <= run_cnt_q + CNT_W'(1);
            end
        end else if (!stop_i) begin
            state_q   <= GRP_RUN;
            run_cnt_q <= '0;
        end
    end

    assign run_o = (state_q == GRP_RUN);

    // R6
    min_run_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        $fell(run_o) |-> ($past(run_cnt_q) >= CNT_LAST));

    // R1
    stop_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        $fell(run_o) |-> $past(stop_i));

    // R2
    restart_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
        $rose(run_o) |-> !$past(stop_i));

endmodule

// File: rtl/gate_cell.sv
// One glitch-free clock gate: enable captured on the falling edge,
// ANDed with the source clock so high phases are never cut.
// Assumes: allow_i is stable around falling edges (it comes from
// rising-edge logic); mask_i may change at any time outside a falling edge.
module gate_cell (
    input  logic clk_i,
    input  logic rst_n,
    input  logic allow_i,
    input  logic mask_i,
    output logic gclk_o
);

    logic en_q;

    // Capture the enable while the source clock is low
    always_ff @(negedge clk_i) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= allow_i & mask_i;
    end

    assign gclk_o = clk_i & en_q;

    // R3 R5
    park_low_chk: assert property (@(negedge clk_i) disable iff (!rst_n)
        !(allow_i && mask_i) |=> !gclk_o);

endmodule

// File: rtl/clk_stop_gate.sv
// Top of the clock group stop gate: synchronizer, run controller and
// one gate cell per output.
// Assumes: one source clock for the whole group; reset is synchronous.
module clk_stop_gate #(
    parameter int N_OUT       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int MIN_RUN     = 100
) (
    input  logic             clk_i,
    input  logic             rst_n,
    input  logic             stop_req_n,
    input  logic [N_OUT-1:0] out_en_mask,
    output logic [N_OUT-1:0] gclk_o,
    output logic             stopped_o
);

    logic stop_s;
    logic run_w;

    stop_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk_i   (clk_i),
        .rst_n   (rst_n),
        .req_n_i (stop_req_n),
        .stop_o  (stop_s)
    );

    run_ctrl #(.MIN_RUN(MIN_RUN)) ctrl_i (
        .clk_i  (clk_i),
        .rst_n  (rst_n),
        .stop_i (stop_s),
        .run_o  (run_w)
    );

    generate
        for (genvar g = 0; g < N_OUT; g++) begin : g_gate
            gate_cell cell_i (
                .clk_i   (clk_i),
                .rst_n   (rst_n),
                .allow_i (run_w),
                .mask_i  (out_en_mask[g]),
                .gclk_o  (gclk_o[g])
            );
        end
    endgenerate

    assign stopped_o = ~run_w;

    // R8
    reset_flag_chk: assert property (@(posedge clk_i)
        $past(!rst_n) |-> !stopped_o);

endmodule

// File: tb/clk_stop_gate_tb_top.sv
module clk_stop_gate_tb_top;

    localparam int N  = 4;
    localparam int S  = 2;
    localparam int MR = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stop_n = 1'b1;
    logic [N-1:0] mask = '1;
    logic [N-1:0] gclk;
    logic         stopped;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        int           c;
        logic [N-1:0] vec;
        logic         stp;
        string        tag;
    } item_t;

    item_t exp_q[$];

    clk_stop_gate #(.N_OUT(N), .SYNC_STAGES(S), .MIN_RUN(MR)) dut_i (
        .clk_i       (clk),
        .rst_n       (rst_n),
        .stop_req_n  (stop_n),
        .out_en_mask (mask),
        .gclk_o      (gclk),
        .stopped_o   (stopped)
    );

    always #4 clk = ~clk;

    // Driver helper: queue expectations for cycles a..b
    task automatic push(input int a, input int b, input logic [N-1:0] v,
                        input logic s, input string tag);
        for (int c = a; c <= b; c++) begin
            item_t it;
            it.c = c; it.vec = v; it.stp = s; it.tag = tag;
            exp_q.push_back(it);
        end
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic chk(input string tag, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle=%0d actual=%b expected=%b", tag, cyc, act, exp);
        end
    endtask

    // Monitor: sample high phase twice, low phase once, compare to queue
    always begin
        logic [N-1:0] v1, v2, v3;
        logic s1;
        @(posedge clk);
        cyc++;
        #1 v1 = gclk; s1 = stopped;
        #2 v2 = gclk;
        #2 v3 = gclk;
        while (exp_q.size() > 0 && exp_q[0].c < cyc) begin
            item_t old;
            old = exp_q.pop_front();
            checks++; fails++;
            $display("FAIL %s missed cycle=%0d actual=none expected=sampled", old.tag, old.c);
        end
        if (exp_q.size() > 0 && exp_q[0].c == cyc) begin
            item_t it;
            it = exp_q.pop_front();
            chk({it.tag, " outputs"}, v1, it.vec);
            chk({it.tag, " stopped_o"}, {{(N-1){1'b0}}, s1}, {{(N-1){1'b0}}, it.stp});
            chk("R4 full high phase", v2, v1);
            chk("R4 low phase", v3, '0);
        end
    end

    initial begin
        int e;
        // R8 reset state
        push(2, 3, '0, 1'b0, "R8 in reset");
        wait_to(3);
        rst_n = 1'b1;
        e = cyc;
        push(e + 1, e + 12, 4'hF, 1'b0, "R8 first pulses");
        wait_to(e + 12);

        // R1 stop with bounded latency, R3 parked low
        e = cyc;
        stop_n = 1'b0;
        push(e + 1, e + 2, 4'hF, 1'b0, "R1 pulses before stop");
        push(e + 3, e + 3, 4'hF, 1'b1, "R1 last pulse");
        push(e + 4, e + 10, '0, 1'b1, "R3 stopped low");
        wait_to(e + 10);

        // R5 mask change while stopped is invisible
        e = cyc;
        mask = 4'b0101;
        push(e + 1, e + 4, '0, 1'b1, "R5 mask while stopped");
        wait_to(e + 4);

        // R2 restart
        e = cyc;
        stop_n = 1'b1;
        push(e + 1, e + 2, '0, 1'b1, "R2 before restart");
        push(e + 3, e + 3, '0, 1'b0, "R2 flag clears");
        push(e + 4, e + 14, 4'b0101, 1'b0, "R2 pulses resume");
        wait_to(e + 14);

        // R5 mask change while running
        e = cyc;
        mask = 4'b1010;
        push(e + 1, e + 5, 4'b1010, 1'b0, "R5 mask while running");
        wait_to(e + 5);

        // R1 stop again
        e = cyc;
        stop_n = 1'b0;
        push(e + 1, e + 2, 4'b1010, 1'b0, "R1 pulses before stop");
        push(e + 3, e + 3, 4'b1010, 1'b1, "R1 last pulse");
        push(e + 4, e + 6, '0, 1'b1, "R3 stopped low");
        wait_to(e + 6);

        // R6 early request deferred until MR pulses delivered
        e = cyc;
        stop_n = 1'b1;
        push(e + 1, e + 2, '0, 1'b1, "R2 before restart");
        push(e + 3, e + 3, '0, 1'b0, "R2 flag clears");
        push(e + 4, e + 3 + MR - 1, 4'b1010, 1'b0, "R6 deferred run");
        push(e + 3 + MR, e + 3 + MR, 4'b1010, 1'b1, "R6 stop at min run");
        push(e + 4 + MR, e + 7 + MR, '0, 1'b1, "R6 stopped after min run");
        wait_to(e + 4);
        stop_n = 1'b0;
        wait_to(e + 7 + MR);

        // R7 withdrawn deferred request never stops
        e = cyc;
        stop_n = 1'b1;
        push(e + 1, e + 2, '0, 1'b1, "R2 before restart");
        push(e + 3, e + 3, '0, 1'b0, "R2 flag clears");
        push(e + 4, e + 16, 4'b1010, 1'b0, "R7 withdrawn request");
        wait_to(e + 4);
        stop_n = 1'b0;
        wait_to(e + 6);
        stop_n = 1'b1;
        wait_to(e + 16);

        // R5 whole group masked while running
        e = cyc;
        mask = '0;
        push(e + 1, e + 5, '0, 1'b0, "R5 all masked");
        wait_to(e + 7);

        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R1 leftover actual=%0d expected=0", exp_q.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule